// File: doc/BRIEF.md
# Vector Rename Map with Zero-Upper Tracking

This block is the register alias table for the 256-bit vector register set of an out-of-order core. Each architectural register points at a physical register. Each entry also carries a flag that records whether the upper 128 bits of that register are known to be zero. A group of up to four floating-point micro-ops is renamed each cycle. Each slot sees the updates made by the slots ahead of it in the same group.

The table handles these cases:
- **Full-width writes** take a fresh physical tag from the free list, which supplies one candidate tag per slot.
- **128-bit writes** also take a fresh tag and mark the upper half zero.
- **Zero-all-uppers** marks every entry.
- **Register moves** can be eliminated: the destination shares the source's physical tag and flag. Shared tags carry a reference count, so a tag returns to the free list only after its last committed release.
- **Branches** store a checkpoint of the map, the flags and the reference counts, taken as they stand right after the branch's slot. A mispredict restores that checkpoint in one cycle.

Top module: `vec_zu_rename`

## Requirements
- R1: After reset every architectural register k maps to physical register k and every zero-upper flag is clear. With no requests, `alloc_take` and `out_elim` are zero.
- R2: A valid op of kind 1 (full 256-bit write) takes its slot's `alloc_preg`, raises `alloc_take` and writes flag 0. Kind 2 (128-bit write) does the same but writes flag 1. `out_old_preg` shows the destination's previous mapping.
- R3: Kind 4 (zero all uppers) sets the flag of every entry and takes no physical register.
- R4: Kind 3 (move) with elimination enabled copies the source's physical tag and flag into the destination. It takes no tag and pulses `out_elim` for its slot.
- R5: With `cfg_elim_off` high, a move takes its slot's `alloc_preg`, still copies the source flag, and `out_elim` stays low.
- R6: Within one group, a slot's source, old mapping and flag reflect the writes of all lower-numbered slots of that group.
- R7: `flush_valid` restores every mapping and flag to the checkpoint `flush_tag`, which was taken after the branch's slot. Writes from older slots of the branch's group stay. Writes from younger slots are undone. Rename requests in a flush cycle are dropped: no take, no elimination, no map change.
- R8: A release (`rel_valid`, `rel_preg`) of a tag with no sharers raises `free_valid` with `free_preg` equal to `rel_preg` in the same cycle. Each eliminated move that shares a tag requires one extra release before the tag is freed.
- R9: Sharers added by eliminated moves younger than the branch are removed by the flush, so the tag frees on the first release afterwards.
- Kind 0 is a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_elim_off | input | 1 | Disables move elimination |
| req_valid | input | SLOTS | Per-slot request valid |
| req_kind | input | SLOTS x 3 | Per-slot op kind (0 nop, 1 full, 2 narrow, 3 move, 4 zero-all) |
| req_dst | input | SLOTS x AW | Destination architectural register |
| req_src | input | SLOTS x AW | Source architectural register |
| alloc_preg | input | SLOTS x PW | Free-list candidate tag per slot |
| alloc_take | output | SLOTS | Slot consumed its candidate tag |
| out_dst_preg | output | SLOTS x PW | Destination physical tag |
| out_src_preg | output | SLOTS x PW | Source physical tag |
| out_old_preg | output | SLOTS x PW | Previous destination mapping |
| out_dst_zu | output | SLOTS | Destination zero-upper flag |
| out_elim | output | SLOTS | Eliminated-move event pulse |
| br_valid | input | 1 | Checkpoint capture this cycle |
| br_slot | input | SW | Slot holding the branch |
| br_tag | input | CW | Checkpoint index to capture |
| flush_valid | input | 1 | Mispredict restore |
| flush_tag | input | CW | Checkpoint index to restore |
| rel_valid | input | 1 | Committed release of an old mapping |
| rel_preg | input | PW | Released physical tag |
| free_valid | output | 1 | Tag returned to free list |
| free_preg | output | PW | Tag returned |

## Verification
A mispredict restore can arrive in the same cycle as a new rename group, and in that case the restore wins. The bench provokes this by asserting `flush_valid` together with a valid full-width write. In that cycle it expects no take and no elimination pulse. In later cycles it reads the restored mappings and flags back through the source and destination outputs. It also judges the interaction between restore and reference counts: an eliminated move that lay past the branch and was flushed must no longer hold its tag, so a single release afterwards must free that tag.

// File: rtl/vzr_pkg.sv
package vzr_pkg;
  typedef enum logic [2:0] {
    K_NOP     = 3'd0,
    K_WIDE    = 3'd1,
    K_NARROW  = 3'd2,
    K_MOVE    = 3'd3,
    K_ZEROALL = 3'd4
  } op_kind_e;
endpackage

// File: rtl/vzr_slot_chain.sv
module vzr_slot_chain
  import vzr_pkg::*;
#(
  parameter int unsigned ARCH_REGS = 16,
  parameter int unsigned PHYS_REGS = 64,
  parameter int unsigned SLOTS     = 4,
  localparam int unsigned AW = $clog2(ARCH_REGS),
  localparam int unsigned PW = $clog2(PHYS_REGS),
  localparam int unsigned SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [ARCH_REGS-1:0][PW-1:0] map_q,
  input  logic [ARCH_REGS-1:0]         zu_q,
  input  logic                         elim_off,
  input  logic [SLOTS-1:0]             req_valid,
  input  logic [SLOTS-1:0][2:0]        req_kind,
  input  logic [SLOTS-1:0][AW-1:0]     req_dst,
  input  logic [SLOTS-1:0][AW-1:0]     req_src,
  input  logic [SLOTS-1:0][PW-1:0]     alloc_preg,
  input  logic [SW-1:0]                br_slot,
  output logic [ARCH_REGS-1:0][PW-1:0] map_d,
  output logic [ARCH_REGS-1:0]         zu_d,
  output logic [ARCH_REGS-1:0][PW-1:0] map_br,
  output logic [ARCH_REGS-1:0]         zu_br,
  output logic [SLOTS-1:0][PW-1:0]     dst_preg,
  output logic [SLOTS-1:0][PW-1:0]     src_preg,
  output logic [SLOTS-1:0][PW-1:0]     old_preg,
  output logic [SLOTS-1:0]             dst_zu,
  output logic [SLOTS-1:0]             take,
  output logic [SLOTS-1:0]             elim
);
  logic [ARCH_REGS-1:0][PW-1:0] m;
  logic [ARCH_REGS-1:0]         z;

  // Slots are applied in order; each sees the running map of earlier slots.
  always_comb begin
    m      = map_q;
    z      = zu_q;
    map_br = map_q;
    zu_br  = zu_q;
    for (int s = 0; s < SLOTS; s++) begin
      op_kind_e k;
      logic     wr;
      k           = op_kind_e'(req_kind[s]);
      wr          = 1'b0;
      src_preg[s] = m[req_src[s]];
      old_preg[s] = m[req_dst[s]];
      dst_preg[s] = alloc_preg[s];
      dst_zu[s]   = 1'b0;
      take[s]     = 1'b0;
      elim[s]     = 1'b0;
      if (req_valid[s]) begin
        case (k)
          K_WIDE: begin
            take[s] = 1'b1;
            wr      = 1'b1;
          end
          K_NARROW: begin
            take[s]   = 1'b1;
            dst_zu[s] = 1'b1;
            wr        = 1'b1;
          end
          K_MOVE: begin
            wr        = 1'b1;
            dst_zu[s] = z[req_src[s]];
            if (elim_off) begin
              take[s] = 1'b1;
            end else begin
              elim[s]     = 1'b1;
              dst_preg[s] = m[req_src[s]];
            end
          end
          K_ZEROALL: z = '1;
          default: ;
        endcase
      end
      if (wr) begin
        m[req_dst[s]] = dst_preg[s];
        z[req_dst[s]] = dst_zu[s];
      end
      if (SW'(s) == br_slot) begin
        map_br = m;
        zu_br  = z;
      end
    end
    map_d = m;
    zu_d  = z;
  end
endmodule

// File: rtl/vzr_refcnt.sv
module vzr_refcnt #(
  parameter int unsigned PHYS_REGS = 64,
  parameter int unsigned SLOTS     = 4,
  parameter int unsigned CKPTS     = 4,
  parameter int unsigned CNTW      = 4,
  localparam int unsigned PW = $clog2(PHYS_REGS),
  localparam int unsigned SW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned CW = (CKPTS > 1) ? $clog2(CKPTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SLOTS-1:0]         share_v,
  input  logic [SLOTS-1:0][PW-1:0] share_p,
  input  logic                     br_take,
  input  logic [SW-1:0]            br_slot,
  input  logic [CW-1:0]            br_tag,
  input  logic                     flush,
  input  logic [CW-1:0]            flush_tag,
  input  logic                     rel_valid,
  input  logic [PW-1:0]            rel_preg,
  output logic                     free_valid,
  output logic [PW-1:0]            free_preg
);
  logic [PHYS_REGS-1:0][CNTW-1:0]            cnt_q, cnt_n;
  logic [CKPTS-1:0][PHYS_REGS-1:0][CNTW-1:0] ck_q, ck_n;
  logic                                      ck_en;
  logic [CNTW-1:0]                           eff_cnt;

  assign ck_en = rel_valid | br_take;

  always_comb begin
    cnt_n = cnt_q;
    ck_n  = ck_q;
    for (int p = 0; p < PHYS_REGS; p++) begin
      logic            hit;
      logic [CNTW-1:0] inc_all, inc_br, base, rest;
      hit     = rel_valid && (rel_preg == PW'(p));
      inc_all = '0;
      inc_br  = '0;
      for (int s = 0; s < SLOTS; s++) begin
        if (share_v[s] && (share_p[s] == PW'(p))) begin
          inc_all = inc_all + CNTW'(1);
          if (SW'(s) <= br_slot) inc_br = inc_br + CNTW'(1);
        end
      end
      base = cnt_q[p] - CNTW'(hit && (cnt_q[p] != '0));
      rest = ck_q[flush_tag][p] - CNTW'(hit && (ck_q[flush_tag][p] != '0));
      // Committed releases are older than any live branch: apply to all copies.
      for (int c = 0; c < CKPTS; c++) begin
        if (hit && (ck_q[c][p] != '0)) ck_n[c][p] = ck_q[c][p] - CNTW'(1);
      end
      if (flush) cnt_n[p] = rest;
      else       cnt_n[p] = base + inc_all;
      if (br_take) ck_n[br_tag][p] = base + inc_br;
    end
  end

  assign eff_cnt    = flush ? ck_q[flush_tag][rel_preg] : cnt_q[rel_preg];
  assign free_valid = rel_valid && (eff_cnt == '0);
  assign free_preg  = rel_preg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  always_ff @(posedge clk) begin
    if (ck_en) ck_q <= ck_n;
  end
endmodule

// File: rtl/vec_zu_rename.sv
module vec_zu_rename #(
  parameter int unsigned ARCH_REGS = 16,
  parameter int unsigned PHYS_REGS = 64,
  parameter int unsigned SLOTS     = 4,
  parameter int unsigned CKPTS     = 4,
  localparam int unsigned AW   = $clog2(ARCH_REGS),
  localparam int unsigned PW   = $clog2(PHYS_REGS),
  localparam int unsigned SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned CW   = (CKPTS > 1) ? $clog2(CKPTS) : 1,
  localparam int unsigned CNTW = AW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_elim_off,
  input  logic [SLOTS-1:0]         req_valid,
  input  logic [SLOTS-1:0][2:0]    req_kind,
  input  logic [SLOTS-1:0][AW-1:0] req_dst,
  input  logic [SLOTS-1:0][AW-1:0] req_src,
  input  logic [SLOTS-1:0][PW-1:0] alloc_preg,
  output logic [SLOTS-1:0]         alloc_take,
  output logic [SLOTS-1:0][PW-1:0] out_dst_preg,
  output logic [SLOTS-1:0][PW-1:0] out_src_preg,
  output logic [SLOTS-1:0][PW-1:0] out_old_preg,
  output logic [SLOTS-1:0]         out_dst_zu,
  output logic [SLOTS-1:0]         out_elim,
  input  logic                     br_valid,
  input  logic [SW-1:0]            br_slot,
  input  logic [CW-1:0]            br_tag,
  input  logic                     flush_valid,
  input  logic [CW-1:0]            flush_tag,
  input  logic                     rel_valid,
  input  logic [PW-1:0]            rel_preg,
  output logic                     free_valid,
  output logic [PW-1:0]            free_preg
);
  logic [ARCH_REGS-1:0][PW-1:0]            map_q, map_n, map_d, map_br;
  logic [ARCH_REGS-1:0]                    zu_q, zu_n, zu_d, zu_br;
  logic [CKPTS-1:0][ARCH_REGS-1:0][PW-1:0] ck_map_q;
  logic [CKPTS-1:0][ARCH_REGS-1:0]         ck_zu_q;
  logic [SLOTS-1:0]                        req_live;
  logic                                    br_take;

  // A restore takes priority over the incoming group.
  assign req_live = req_valid & {SLOTS{~flush_valid}};
  assign br_take  = br_valid & ~flush_valid;

  vzr_slot_chain #(
    .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .SLOTS(SLOTS)
  ) u_chain (
    .map_q(map_q), .zu_q(zu_q), .elim_off(cfg_elim_off),
    .req_valid(req_live), .req_kind(req_kind), .req_dst(req_dst),
    .req_src(req_src), .alloc_preg(alloc_preg), .br_slot(br_slot),
    .map_d(map_d), .zu_d(zu_d), .map_br(map_br), .zu_br(zu_br),
    .dst_preg(out_dst_preg), .src_preg(out_src_preg), .old_preg(out_old_preg),
    .dst_zu(out_dst_zu), .take(alloc_take), .elim(out_elim)
  );

  vzr_refcnt #(
    .PHYS_REGS(PHYS_REGS), .SLOTS(SLOTS), .CKPTS(CKPTS), .CNTW(CNTW)
  ) u_refcnt (
    .clk(clk), .rst_n(rst_n), .share_v(out_elim), .share_p(out_src_preg),
    .br_take(br_take), .br_slot(br_slot), .br_tag(br_tag),
    .flush(flush_valid), .flush_tag(flush_tag),
    .rel_valid(rel_valid), .rel_preg(rel_preg),
    .free_valid(free_valid), .free_preg(free_preg)
  );

  always_comb begin
    if (flush_valid) begin
      map_n = ck_map_q[flush_tag];
      zu_n  = ck_zu_q[flush_tag];
    end else begin
      map_n = map_d;
      zu_n  = zu_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < ARCH_REGS; a++) map_q[a] <= PW'(a);
      zu_q <= '0;
    end else begin
      map_q <= map_n;
      zu_q  <= zu_n;
    end
  end

  always_ff @(posedge clk) begin
    if (br_take) begin
      ck_map_q[br_tag] <= map_br;
      ck_zu_q[br_tag]  <= zu_br;
    end
  end
endmodule

// File: rtl/vec_zu_rename_chk.sv
module vec_zu_rename_chk #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned PW    = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_elim_off,
  input logic [SLOTS-1:0]         req_valid,
  input logic [SLOTS-1:0][2:0]    req_kind,
  input logic [SLOTS-1:0]         alloc_take,
  input logic [SLOTS-1:0][PW-1:0] out_dst_preg,
  input logic [SLOTS-1:0][PW-1:0] out_src_preg,
  input logic [SLOTS-1:0]         out_dst_zu,
  input logic [SLOTS-1:0]         out_elim,
  input logic                     flush_valid,
  input logic                     rel_valid,
  input logic                     free_valid
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    // R4: an eliminated move reuses the source tag
    p_elim_shares_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_elim[s] |-> (out_dst_preg[s] == out_src_preg[s]));
    // R4: an eliminated move consumes no free-list tag
    p_elim_no_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_elim[s] |-> !alloc_take[s]);
    // R5: disable bit suppresses elimination
    p_elim_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_elim_off |-> !out_elim[s]);
    // R2: narrow write marks the upper half zero
    p_narrow_zu_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[s] && req_kind[s] == 3'd2 && !flush_valid) |-> out_dst_zu[s]);
    // R2: a tag is only taken for a live request
    p_take_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_take[s] |-> req_valid[s]);
  end

  // R7: a restore cycle drops the rename group
  p_flush_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (alloc_take == '0 && out_elim == '0));
  // R8: freeing happens only on a release
  p_free_on_rel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> rel_valid);
endmodule

bind vec_zu_rename vec_zu_rename_chk #(.SLOTS(SLOTS), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_elim_off(cfg_elim_off),
  .req_valid(req_valid), .req_kind(req_kind), .alloc_take(alloc_take),
  .out_dst_preg(out_dst_preg), .out_src_preg(out_src_preg),
  .out_dst_zu(out_dst_zu), .out_elim(out_elim),
  .flush_valid(flush_valid), .rel_valid(rel_valid), .free_valid(free_valid)
);

// File: tb/vec_zu_rename_tb.sv
module vec_zu_rename_tb;
  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_elim_off;
  logic [3:0]       req_valid;
  logic [3:0][2:0]  req_kind;
  logic [3:0][3:0]  req_dst, req_src;
  logic [3:0][5:0]  alloc_preg;
  logic [3:0]       alloc_take;
  logic [3:0][5:0]  out_dst_preg, out_src_preg, out_old_preg;
  logic [3:0]       out_dst_zu, out_elim;
  logic             br_valid;
  logic [1:0]       br_slot, br_tag;
  logic             flush_valid;
  logic [1:0]       flush_tag;
  logic             rel_valid;
  logic [5:0]       rel_preg;
  logic             free_valid;
  logic [5:0]       free_preg;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  vec_zu_rename u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_elim_off(cfg_elim_off),
    .req_valid(req_valid), .req_kind(req_kind), .req_dst(req_dst),
    .req_src(req_src), .alloc_preg(alloc_preg), .alloc_take(alloc_take),
    .out_dst_preg(out_dst_preg), .out_src_preg(out_src_preg),
    .out_old_preg(out_old_preg), .out_dst_zu(out_dst_zu), .out_elim(out_elim),
    .br_valid(br_valid), .br_slot(br_slot), .br_tag(br_tag),
    .flush_valid(flush_valid), .flush_tag(flush_tag),
    .rel_valid(rel_valid), .rel_preg(rel_preg),
    .free_valid(free_valid), .free_preg(free_preg)
  );

  typedef struct packed {
    logic [2:0] k;
    logic [3:0] d;
    logic [3:0] s;
    logic [5:0] a;
    logic [5:0] ed;
    logic [5:0] es;
    logic [5:0] eo;
    logic       ez;
    logic       et;
    logic       ee;
    logic       chk;
  } vec_t;

  // kind, dst, src, alloc, exp dst, exp src, exp old, zu, take, elim, check tags
  localparam vec_t TBL [9] = '{
    '{3'd1, 4'd1, 4'd0, 6'd20, 6'd20, 6'd0,  6'd1,  1'b0, 1'b1, 1'b0, 1'b1},
    '{3'd2, 4'd2, 4'd1, 6'd21, 6'd21, 6'd20, 6'd2,  1'b1, 1'b1, 1'b0, 1'b1},
    '{3'd3, 4'd3, 4'd2, 6'd0,  6'd21, 6'd21, 6'd3,  1'b1, 1'b0, 1'b1, 1'b1},
    '{3'd3, 4'd4, 4'd1, 6'd0,  6'd20, 6'd20, 6'd4,  1'b0, 1'b0, 1'b1, 1'b1},
    '{3'd4, 4'd0, 4'd0, 6'd0,  6'd0,  6'd0,  6'd0,  1'b0, 1'b0, 1'b0, 1'b0},
    '{3'd3, 4'd5, 4'd1, 6'd0,  6'd20, 6'd20, 6'd5,  1'b1, 1'b0, 1'b1, 1'b1},
    '{3'd1, 4'd5, 4'd5, 6'd22, 6'd22, 6'd20, 6'd20, 1'b0, 1'b1, 1'b0, 1'b1},
    '{3'd2, 4'd6, 4'd3, 6'd23, 6'd23, 6'd21, 6'd6,  1'b1, 1'b1, 1'b0, 1'b1},
    '{3'd3, 4'd7, 4'd6, 6'd0,  6'd23, 6'd23, 6'd7,  1'b1, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = '0; req_kind = '0; req_dst = '0; req_src = '0; alloc_preg = '0;
    br_valid = 0; br_slot = 0; br_tag = 0; flush_valid = 0; flush_tag = 0;
    rel_valid = 0; rel_preg = 0;
  endtask

  task automatic slot(input int s, input int k, input int d, input int sr, input int a);
    req_valid[s]  = 1'b1;
    req_kind[s]   = 3'(k);
    req_dst[s]    = 4'(d);
    req_src[s]    = 4'(sr);
    alloc_preg[s] = 6'(a);
  endtask

  task automatic next();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic release_tag(input int p, input int exp_free);
    rel_valid = 1; rel_preg = 6'(p);
    @(negedge clk);
    check("R8", "free_valid", int'(free_valid), exp_free);
    if (exp_free == 1) check("R8", "free_preg", int'(free_preg), p);
    next();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    cfg_elim_off = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset identity map, nothing taken or eliminated
    for (int s = 0; s < 4; s++) req_src[s] = 4'(s + 12);
    @(negedge clk);
    for (int s = 0; s < 4; s++) check("R1", "src map", int'(out_src_preg[s]), s + 12);
    check("R1", "take", int'(alloc_take), 0);
    check("R1", "elim", int'(out_elim), 0);
    check("R1", "free", int'(free_valid), 0);
    next();

    // R2 R3 R4: table of single-slot ops
    for (int i = 0; i < 9; i++) begin
      slot(0, int'(TBL[i].k), int'(TBL[i].d), int'(TBL[i].s), int'(TBL[i].a));
      @(negedge clk);
      check("R2/R4", "take", int'(alloc_take[0]), int'(TBL[i].et));
      check("R4", "elim", int'(out_elim[0]), int'(TBL[i].ee));
      if (TBL[i].chk) begin
        check("R2/R4", "dst", int'(out_dst_preg[0]), int'(TBL[i].ed));
        check("R2/R4", "src", int'(out_src_preg[0]), int'(TBL[i].es));
        check("R2", "old", int'(out_old_preg[0]), int'(TBL[i].eo));
        check("R3/R4", "zu", int'(out_dst_zu[0]), int'(TBL[i].ez));
      end
      next();
    end

    // R8: reference-counted release
    release_tag(22, 1);
    release_tag(20, 0);
    release_tag(20, 0);
    release_tag(20, 1);

    // R5: elimination disabled
    cfg_elim_off = 1;
    slot(0, 3, 8, 2, 30);
    @(negedge clk);
    check("R5", "take", int'(alloc_take[0]), 1);
    check("R5", "elim", int'(out_elim[0]), 0);
    check("R5", "dst", int'(out_dst_preg[0]), 30);
    check("R5", "zu", int'(out_dst_zu[0]), 1);
    next();
    cfg_elim_off = 0;

    // R6: in-group forwarding
    slot(0, 1, 9, 0, 31);
    slot(1, 3, 10, 9, 0);
    slot(2, 2, 9, 0, 32);
    slot(3, 3, 11, 9, 0);
    @(negedge clk);
    check("R6", "s1 dst", int'(out_dst_preg[1]), 31);
    check("R6", "s1 zu", int'(out_dst_zu[1]), 0);
    check("R6", "s2 old", int'(out_old_preg[2]), 31);
    check("R6", "s3 dst", int'(out_dst_preg[3]), 32);
    check("R6", "s3 zu", int'(out_dst_zu[3]), 1);
    check("R6", "elim", int'(out_elim), 4'b1010);
    next();

    // R7: group with branch in slot 1, younger slots later flushed
    slot(0, 2, 12, 0, 33);
    slot(1, 1, 13, 0, 34);
    slot(2, 3, 14, 12, 0);
    slot(3, 1, 12, 0, 35);
    br_valid = 1; br_slot = 2'd1; br_tag = 2'd2;
    @(negedge clk);
    check("R6", "s3 old", int'(out_old_preg[3]), 33);
    next();
    flush_valid = 1; flush_tag = 2'd2;
    slot(0, 1, 12, 0, 40);
    @(negedge clk);
    check("R7", "flush take", int'(alloc_take), 0);
    check("R7", "flush elim", int'(out_elim), 0);
    next();
    cfg_elim_off = 1;
    slot(0, 3, 15, 12, 41);
    slot(1, 3, 0, 13, 42);
    slot(2, 3, 1, 14, 43);
    @(negedge clk);
    check("R7", "arch12 tag", int'(out_src_preg[0]), 33);
    check("R7", "arch12 zu", int'(out_dst_zu[0]), 1);
    check("R7", "arch13 tag", int'(out_src_preg[1]), 34);
    check("R7", "arch13 zu", int'(out_dst_zu[1]), 0);
    check("R7", "arch14 tag", int'(out_src_preg[2]), 14);
    check("R7", "arch14 zu", int'(out_dst_zu[2]), 1);
    next();
    cfg_elim_off = 0;

    // R9: squashed sharer no longer holds the tag
    rel_valid = 1; rel_preg = 6'd33;
    @(negedge clk);
    check("R9", "free after flush", int'(free_valid), 1);
    next();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule